// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the operand location for one instruction of an 8-bit accumulator-style processor. Each instruction presents a mode code, up to two operand bytes taken from the instruction stream, the address of the opcode (program counter) and the 16-bit index register. From these the block produces a 16-bit effective address and three class flags. The flags say whether that address is valid, whether the operand lives in a register, or whether the mode code was not recognised.

The address arithmetic is purely combinational. The result is captured in an output register on a rising clock edge whenever the load strobe is high, and it holds until the next strobe. All 16-bit sums wrap modulo 65536. Decoding the opcode into a mode code, the memory access itself and the ALU belong to the surrounding core.

Mode codes: 0 implied, 1 accumulator, 2 immediate 8-bit, 3 immediate 16-bit, 4 direct, 5 extended, 6 relative, 7 indexed, 8 to 15 undefined.

Top module: `oper_ea_gen`

## Requirements
- R1: A synchronous active-high reset clears the address and all three flags to zero on the next rising edge, and it wins over a load strobe in the same cycle.
- R2: While the load strobe is low, the address and flags keep their previous values whatever the other inputs do.
- R3: Mode 4 (direct) gives the address {8'h00, first byte}, so the result always lies in 0x0000 to 0x00FF, with the valid flag set.
- R4: Mode 5 (extended) gives the address {first byte, second byte}, first byte high, with the valid flag set.
- R5: Mode 6 (relative) gives program counter + 2 + the first byte sign-extended, modulo 65536, with the valid flag set.
- R6: Mode 7 (indexed) gives index register + the first byte zero-extended, modulo 65536, with the valid flag set.
- R7: Modes 2 and 3 (immediate, 8 or 16 bit) give program counter + 1, modulo 65536, with the valid flag set.
- R8: Modes 0 and 1 (implied, accumulator) set the in-register flag, clear the valid flag and give address 0.
- R9: Mode codes 8 to 15 set the error flag, clear the valid and in-register flags and give address 0.
- R10: After any load, exactly one of the valid, in-register and error flags is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for the computed result |
| mode | input | 4 | Addressing mode code |
| opnd_hi | input | 8 | First operand byte after the opcode |
| opnd_lo | input | 8 | Second operand byte after the opcode |
| pc | input | 16 | Address of the opcode |
| ix | input | 16 | Index register |
| ea | output | 16 | Registered effective address |
| ea_valid | output | 1 | Address refers to memory |
| in_reg | output | 1 | Operand is held in a register |
| bad_mode | output | 1 | Mode code not recognised |

## Verification
The load strobe and the synchronous reset can land on the same clock edge, and only one of them may shape the outputs. The bench holds a valid address in the register, then raises reset together with a load carrying a nonzero extended-mode result, and requires all outputs to read zero one edge later. It separately drives wrap-around sums in relative and indexed modes, a backward branch, the page-zero boundary and the undefined codes.

// File: rtl/oeag_pkg.sv
package oeag_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    // Mode codes seen at the block's input
    localparam logic [3:0] MC_IMPL  = 4'd0;
    localparam logic [3:0] MC_ACC   = 4'd1;
    localparam logic [3:0] MC_IMM8  = 4'd2;
    localparam logic [3:0] MC_IMM16 = 4'd3;
    localparam logic [3:0] MC_DIR   = 4'd4;
    localparam logic [3:0] MC_EXT   = 4'd5;
    localparam logic [3:0] MC_REL   = 4'd6;
    localparam logic [3:0] MC_IDX   = 4'd7;

    // Internal address source selected by the decoder
    typedef enum logic [2:0] {
        SRC_REG,
        SRC_PCNEXT,
        SRC_PAGE0,
        SRC_LIT,
        SRC_PCREL,
        SRC_INDEX,
        SRC_BAD
    } src_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic              in_reg;
        logic              bad;
    } ea_res_t;

    function automatic logic [ADDR_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
        return {{(ADDR_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

    function automatic logic [ADDR_W-1:0] zext_byte(input logic [BYTE_W-1:0] b);
        return {{(ADDR_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/oeag_mode_dec.sv
module oeag_mode_dec
    import oeag_pkg::*;
(
    input  logic [3:0] mode_code,
    output src_e       src
);

    always_comb begin
        unique case (mode_code)
            MC_IMPL, MC_ACC:   src = SRC_REG;
            MC_IMM8, MC_IMM16: src = SRC_PCNEXT;
            MC_DIR:            src = SRC_PAGE0;
            MC_EXT:            src = SRC_LIT;
            MC_REL:            src = SRC_PCREL;
            MC_IDX:            src = SRC_INDEX;
            default:           src = SRC_BAD;
        endcase
    end

endmodule

// File: rtl/oeag_addr_calc.sv
module oeag_addr_calc
    import oeag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  src_e            src,
    input  logic [BW-1:0]   b_first,
    input  logic [BW-1:0]   b_second,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   ix,
    output ea_res_t         res
);

    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [AW-1:0] pc_next;
    logic [AW-1:0] pc_rel;
    logic [AW-1:0] ix_off;

    assign pc_next = pc + ONE;
    assign pc_rel  = pc + TWO + sext_byte(b_first);
    assign ix_off  = ix + zext_byte(b_first);

    always_comb begin
        res = '0;
        unique case (src)
            SRC_REG: res.in_reg = 1'b1;
            SRC_PCNEXT: begin
                res.addr  = pc_next;
                res.valid = 1'b1;
            end
            SRC_PAGE0: begin
                res.addr  = zext_byte(b_first);
                res.valid = 1'b1;
            end
            SRC_LIT: begin
                res.addr  = {b_first, b_second};
                res.valid = 1'b1;
            end
            SRC_PCREL: begin
                res.addr  = pc_rel;
                res.valid = 1'b1;
            end
            SRC_INDEX: begin
                res.addr  = ix_off;
                res.valid = 1'b1;
            end
            default: res.bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/oper_ea_gen.sv
module oper_ea_gen
    import oeag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [3:0]  mode,
    input  logic [7:0]  opnd_hi,
    input  logic [7:0]  opnd_lo,
    input  logic [15:0] pc,
    input  logic [15:0] ix,
    output logic [15:0] ea,
    output logic        ea_valid,
    output logic        in_reg,
    output logic        bad_mode
);

    src_e    src;
    ea_res_t comb_res;
    ea_res_t q;

    oeag_mode_dec u_dec (
        .mode_code (mode),
        .src       (src)
    );

    oeag_addr_calc #(.AW(ADDR_W), .BW(BYTE_W)) u_calc (
        .src      (src),
        .b_first  (opnd_hi),
        .b_second (opnd_lo),
        .pc       (pc),
        .ix       (ix),
        .res      (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= comb_res;
    end

    assign ea       = q.addr;
    assign ea_valid = q.valid;
    assign in_reg   = q.in_reg;
    assign bad_mode = q.bad;

    // Reset clears everything, even with load high
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ea == 16'h0 && !ea_valid && !in_reg && !bad_mode));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(ea) && $stable(ea_valid) && $stable(in_reg) && $stable(bad_mode)));

    p_page_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (load && mode == MC_DIR) |=> (ea[15:8] == 8'h00 && ea_valid));

    p_reg_no_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (load && (mode == MC_IMPL || mode == MC_ACC)) |=> (in_reg && !ea_valid && ea == 16'h0));

    p_undef_r9: assert property (@(posedge clk) disable iff (rst)
        (load && mode[3]) |=> (bad_mode && !ea_valid && !in_reg));

    p_one_class_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> ($countones({ea_valid, in_reg, bad_mode}) == 1));

endmodule

// File: tb/oper_ea_gen_tb_top.sv
module oper_ea_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        load;
    logic [3:0]  mode;
    logic [7:0]  opnd_hi, opnd_lo;
    logic [15:0] pc, ix;
    logic [15:0] ea;
    logic        ea_valid, in_reg, bad_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oper_ea_gen dut_i (
        .clk(clk), .rst(rst), .load(load), .mode(mode),
        .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .pc(pc), .ix(ix),
        .ea(ea), .ea_valid(ea_valid), .in_reg(in_reg), .bad_mode(bad_mode)
    );

    task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got ea=%h v=%b r=%b e=%b, want ea=%h v=%b r=%b e=%b",
                     req, act[18:3], act[2], act[1], act[0],
                     exp[18:3], exp[2], exp[1], exp[0]);
        end
    endtask

    function automatic logic [18:0] outs();
        return {ea, ea_valid, in_reg, bad_mode};
    endfunction

    // one load, result checked on the following falling edge
    task automatic apply(input logic [3:0] m, input logic [7:0] b1, input logic [7:0] b2,
                         input logic [15:0] p, input logic [15:0] x);
        @(negedge clk);
        mode = m; opnd_hi = b1; opnd_lo = b2; pc = p; ix = x; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic t_reset();   // R1
        @(negedge clk); rst = 1'b1; load = 1'b0;
        @(negedge clk); rst = 1'b0;
        chk("R1 reset", outs(), 19'h0);
    endtask

    task automatic t_reg_modes();   // R8, R10
        apply(4'd0, 8'h12, 8'h34, 16'h1000, 16'h2000);
        chk("R8 implied", outs(), {16'h0, 3'b010});
        apply(4'd1, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF);
        chk("R8 accumulator R10", outs(), {16'h0, 3'b010});
    endtask

    task automatic t_immediate();   // R7
        apply(4'd2, 8'h00, 8'h00, 16'h4000, 16'h0);
        chk("R7 imm8", outs(), {16'h4001, 3'b100});
        apply(4'd3, 8'hAB, 8'hCD, 16'hFFFF, 16'h0);
        chk("R7 imm16 wrap", outs(), {16'h0000, 3'b100});
    endtask

    task automatic t_direct();   // R3
        apply(4'd4, 8'h00, 8'h77, 16'hC000, 16'h5555);
        chk("R3 direct low", outs(), {16'h0000, 3'b100});
        apply(4'd4, 8'hFF, 8'h77, 16'hC000, 16'h5555);
        chk("R3 direct top", outs(), {16'h00FF, 3'b100});
    endtask

    task automatic t_extended();   // R4
        apply(4'd5, 8'hBE, 8'hEF, 16'h0, 16'h0);
        chk("R4 extended", outs(), {16'hBEEF, 3'b100});
    endtask

    task automatic t_relative();   // R5
        logic [15:0] e;
        e = 16'h2000 + 16'd2 + 16'h0010;
        apply(4'd6, 8'h10, 8'h00, 16'h2000, 16'h0);
        chk("R5 forward", outs(), {e, 3'b100});
        e = 16'h2000 + 16'd2 - 16'd128;
        apply(4'd6, 8'h80, 8'h00, 16'h2000, 16'h0);
        chk("R5 backward", outs(), {e, 3'b100});
        apply(4'd6, 8'h05, 8'h00, 16'hFFFE, 16'h0);
        chk("R5 wrap", outs(), {16'h0005, 3'b100});
    endtask

    task automatic t_indexed();   // R6
        apply(4'd7, 8'h80, 8'h00, 16'h0, 16'h1000);
        chk("R6 unsigned offset", outs(), {16'h1080, 3'b100});
        apply(4'd7, 8'hFF, 8'h00, 16'h0, 16'hFF80);
        chk("R6 wrap", outs(), {16'h007F, 3'b100});
    endtask

    task automatic t_undefined();   // R9
        apply(4'd8, 8'h11, 8'h22, 16'h3000, 16'h0);
        chk("R9 code 8", outs(), {16'h0, 3'b001});
        apply(4'd15, 8'h11, 8'h22, 16'h3000, 16'h0);
        chk("R9 code 15", outs(), {16'h0, 3'b001});
    endtask

    task automatic t_hold();   // R2
        apply(4'd5, 8'h12, 8'h34, 16'h0, 16'h0);
        @(negedge clk);
        mode = 4'd6; opnd_hi = 8'h99; pc = 16'h7777; ix = 16'h8888;
        @(negedge clk);
        @(negedge clk);
        chk("R2 hold", outs(), {16'h1234, 3'b100});
    endtask

    task automatic t_reset_vs_load();   // R1 with load in the same cycle
        apply(4'd7, 8'h01, 8'h00, 16'h0, 16'h4000);
        @(negedge clk);
        rst = 1'b1; load = 1'b1; mode = 4'd5; opnd_hi = 8'hAA; opnd_lo = 8'h55;
        @(negedge clk);
        rst = 1'b0; load = 1'b0;
        chk("R1 reset beats load", outs(), 19'h0);
    endtask

    initial begin
        rst = 1'b1; load = 1'b0; mode = '0; opnd_hi = '0; opnd_lo = '0; pc = '0; ix = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reg_modes();
        t_immediate();
        t_direct();
        t_extended();
        t_relative();
        t_indexed();
        t_undefined();
        t_hold();
        t_reset_vs_load();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule